// File: doc/BRIEF.md
# Rate-Limited Latching Interrupt Controller

This block raises a single active-low interrupt request for a sensing peripheral. It has two sources. The first is fresh data in a buffer FIFO, seen as a falling edge on the FIFO's "no data" flag. The second is a fault status word that becomes nonzero. Each source has its own latched status bit. The request pin is pulled low while either bit is set. A bit is released only by the register access that services its own source: any FIFO register access for data, a fault register write for a fault. The pin is open-drain. The block drives an output enable and a data value that is always zero, and an external pull-up gives the high level.

Triggers are rate-limited. When an interrupt fires, a holdoff state machine loads a down-counter for H = (tparam + 5) × max(rate, 1) × 4 clock cycles. Both fields are 4 bits wide and are sampled at the firing edge. The machine has two states. READY allows a fire. HOLD counts down and blocks fires. The transition FIRE takes READY to HOLD. The transition EXPIRE takes HOLD back to READY in the cycle in which the counter would step from 1 to 0. An event that arrives during HOLD is kept pending and fires in the first READY cycle. Successive fires are therefore exactly H cycles apart.

A global enable gates everything. While it is low, new events are dropped and pending events are discarded. After reset the previous-value registers read "FIFO not empty" and "fault nonzero". A level that is already present when reset is released therefore causes no trigger.

Top module: `irq_rate_latch`

## Requirements
- R1: A data interrupt fires when `nodata_flag` is 0 in a cycle after it was 1 in the previous cycle. `irq_oe` reads 1 after that same clock edge.
- R2: Holding `nodata_flag` at 0, or raising it from 0 to 1, produces no data interrupt.
- R3: A cycle with `fifo_access` high releases the data status bit. A `fault_wr` pulse does not release it.
- R4: A fault interrupt fires when `fault_word` goes from all-zero to any nonzero value. A change from one nonzero value to another does not fire.
- R5: The fault status bit is released only by `fault_wr`. A `fifo_access` pulse leaves it set.
- R6: While `irq_en` is 0, no event sets the output, and any pending event is discarded. It does not fire after `irq_en` returns to 1.
- R7: After a fire, no further fire occurs for H = (tparam_cfg + 5) × rate_cfg × 4 cycles. An event that arrives during that window fires exactly H cycles after the previous fire.
- R8: A `rate_cfg` of 0 is treated as 1. For example, tparam_cfg = 2 gives H = 28.
- R9: `irq_dat` is always 0. With a pull-up, the pin reads 0 exactly when `irq_oe` is 1.
- R10: During and after reset `irq_oe` is 0 and the machine is READY, so the first event fires immediately.
- R11: When both status bits are set, the output stays asserted until both have been serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Global interrupt enable |
| rate_cfg | input | RW (4) | Rate multiplier for the holdoff, where 0 counts as 1 |
| tparam_cfg | input | TW (4) | Timing parameter for the holdoff |
| nodata_flag | input | 1 | 1 when the FIFO is empty |
| fault_word | input | FW (8) | Fault status, where nonzero means a fault |
| fifo_access | input | 1 | One-cycle strobe for a FIFO register read or write |
| fault_wr | input | 1 | One-cycle strobe for a fault register write |
| irq_oe | output | 1 | Output enable, where 1 pulls the request pin low |
| irq_dat | output | 1 | Pin data value, constant 0 |

## Verification
The hardest case to reach from the ports is an event that arrives while HOLD is active. It has to be shown to fire in exactly the cycle of EXPIRE and not one cycle earlier or later. The second hard case is a pending event that is dropped because the enable falls and rises again inside the window. An active first source would mask both cases on the pin. The stimulus therefore fires one source, services it on the next cycle so the pin is released, and then applies the other source's event. The pin must then stay released through the rest of the window and drop in cycle H. The bench uses three rate and parameter settings, one of them with rate 0.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    typedef enum logic {
        HO_READY = 1'b0,
        HO_HOLD  = 1'b1
    } holdoff_state_t;

    // Holdoff length in cycles: (tparam + 5) * max(rate,1) * 4
    function automatic int unsigned hold_cycles(input int unsigned tparam,
                                                input int unsigned rate);
        int unsigned r;
        r = (rate == 0) ? 1 : rate;
        return (tparam + 5) * r * 4;
    endfunction

endpackage

// File: rtl/irqr_edge.sv
module irqr_edge #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nodata_flag,
    input  logic [FW-1:0] fault_word,
    output logic          ev_data,
    output logic          ev_fault
);
    logic nd_prev;
    logic fz_prev;

    // Reset values suppress triggers from levels present at reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nd_prev <= 1'b0;
            fz_prev <= 1'b0;
        end else begin
            nd_prev <= nodata_flag;
            fz_prev <= (fault_word == '0);
        end
    end

    assign ev_data  = nd_prev & ~nodata_flag;
    assign ev_fault = fz_prev & (fault_word != '0);

endmodule

// File: rtl/irqr_holdoff.sv
module irqr_holdoff
    import irqr_pkg::*;
#(
    parameter int RW = 4,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [RW-1:0] rate_cfg,
    input  logic [TW-1:0] tparam_cfg,
    output logic          ready
);
    localparam int unsigned MAXH = ((1 << TW) - 1 + 5) * ((1 << RW) - 1) * 4;
    localparam int CW = $clog2(MAXH + 1);

    holdoff_state_t state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic [CW-1:0]  load_val;

    assign load_val = CW'(hold_cycles(int'(tparam_cfg), int'(rate_cfg)) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HO_READY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            HO_READY: begin
                if (fire) begin            // FIRE
                    state_nx = HO_HOLD;
                    cnt_nx   = load_val;
                end
            end
            HO_HOLD: begin
                if (cnt == CW'(1)) begin   // EXPIRE
                    state_nx = HO_READY;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt - CW'(1);
                end
            end
            default: begin
                state_nx = HO_READY;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        ready = (state == HO_READY);
    end

    AST_NO_FIRE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HO_HOLD) |-> !fire); // R7
    AST_FIRE_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state == HO_HOLD)); // R7

endmodule

// File: rtl/irqr_latch.sv
module irqr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic ready,
    input  logic ev_data,
    input  logic ev_fault,
    input  logic fifo_access,
    input  logic fault_wr,
    output logic fire,
    output logic stat_data,
    output logic stat_fault
);
    logic pend_data, pend_fault;
    logic q_data, q_fault;

    assign q_data  = irq_en & (ev_data  | pend_data);
    assign q_fault = irq_en & (ev_fault | pend_fault);
    assign fire    = ready & (q_data | q_fault);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_data  <= 1'b0;
            pend_fault <= 1'b0;
            stat_data  <= 1'b0;
            stat_fault <= 1'b0;
        end else begin
            if (!irq_en || fire) begin
                pend_data  <= 1'b0;
                pend_fault <= 1'b0;
            end else begin
                if (ev_data)  pend_data  <= 1'b1;
                if (ev_fault) pend_fault <= 1'b1;
            end
            if (fire && q_data)   stat_data <= 1'b1;
            else if (fifo_access) stat_data <= 1'b0;
            if (fire && q_fault)  stat_fault <= 1'b1;
            else if (fault_wr)    stat_fault <= 1'b0;
        end
    end

    AST_DATA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_access && !(fire && ev_data) && !pend_data) |=> !stat_data); // R3
    AST_FAULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_fault && !fault_wr) |=> stat_fault); // R5
    AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_data && !fifo_access) |=> stat_data); // R3

endmodule

// File: rtl/irq_rate_latch.sv
module irq_rate_latch
    import irqr_pkg::*;
#(
    parameter int FW = 8,
    parameter int RW = 4,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    input  logic [RW-1:0] rate_cfg,
    input  logic [TW-1:0] tparam_cfg,
    input  logic          nodata_flag,
    input  logic [FW-1:0] fault_word,
    input  logic          fifo_access,
    input  logic          fault_wr,
    output logic          irq_oe,
    output logic          irq_dat
);
    logic ev_data, ev_fault, ready, fire, stat_data, stat_fault;

    irqr_edge #(.FW(FW)) u_edge (
        .clk(clk), .rst_n(rst_n), .nodata_flag(nodata_flag),
        .fault_word(fault_word), .ev_data(ev_data), .ev_fault(ev_fault)
    );

    irqr_latch u_latch (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .ready(ready),
        .ev_data(ev_data), .ev_fault(ev_fault), .fifo_access(fifo_access),
        .fault_wr(fault_wr), .fire(fire), .stat_data(stat_data),
        .stat_fault(stat_fault)
    );

    irqr_holdoff #(.RW(RW), .TW(TW)) u_hold (
        .clk(clk), .rst_n(rst_n), .fire(fire), .rate_cfg(rate_cfg),
        .tparam_cfg(tparam_cfg), .ready(ready)
    );

    assign irq_oe  = stat_data | stat_fault;
    assign irq_dat = 1'b0;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq_oe) |=> !irq_oe); // R6
    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe) |-> $past(irq_en)); // R6

endmodule

// File: tb/irq_rate_latch_bench.sv
`timescale 1ns/100ps
module irq_rate_latch_bench;

    typedef struct {
        logic  chk;
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_en = 1'b1;
    logic [3:0] rate_cfg = 4'd1;
    logic [3:0] tparam_cfg = 4'd0;
    logic       nodata_flag = 1'b1;
    logic [7:0] fault_word = 8'd0;
    logic       fifo_access = 1'b0;
    logic       fault_wr = 1'b0;
    logic       irq_oe, irq_dat;
    wire        irq_pin = irq_oe ? irq_dat : 1'b1; // pull-up resolution

    // staging values applied at the next negedge
    logic       s_rst = 1'b0, s_en = 1'b1, s_nd = 1'b1, s_fa = 1'b0, s_fw = 1'b0;
    logic [3:0] s_rate = 4'd1, s_tp = 4'd0;
    logic [7:0] s_fault = 8'd0;

    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    irq_rate_latch u_irq_rate_latch (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rate_cfg(rate_cfg),
        .tparam_cfg(tparam_cfg), .nodata_flag(nodata_flag),
        .fault_word(fault_word), .fifo_access(fifo_access),
        .fault_wr(fault_wr), .irq_oe(irq_oe), .irq_dat(irq_dat)
    );

    task automatic step(input logic chk, input logic exp, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = ~s_rst; irq_en = s_en; rate_cfg = s_rate; tparam_cfg = s_tp;
        nodata_flag = s_nd; fault_word = s_fault;
        fifo_access = s_fa; fault_wr = s_fw;
        s_fa = 1'b0; s_fw = 1'b0;
        it.chk = chk; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(input int n, input logic exp, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, exp, tag);
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                if (it.chk) begin
                    n_tests++;
                    if (irq_oe !== it.exp || irq_pin !== ~it.exp || irq_dat !== 1'b0) begin
                        n_fail++;
                        $display("FAIL %s: oe=%b pin=%b dat=%b expected oe=%b pin=%b dat=0",
                                 it.tag, irq_oe, irq_pin, irq_dat, it.exp, ~it.exp);
                    end
                end
            end
        end
    end

    // holdoff with a pending data event: fault fires, is serviced, data event waits
    task automatic holdoff_case(input logic [3:0] rate, input logic [3:0] tp,
                                input int h, input string tag);
        s_rate = rate; s_tp = tp;
        s_fault = 8'h05; step(1'b1, 1'b1, {tag, " fire"});
        s_fw = 1'b1;     step(1'b1, 1'b0, {tag, " serviced"});
        s_nd = 1'b0;     step(1'b1, 1'b0, {tag, " pending"});
        for (int k = 3; k < h; k++) step(1'b1, 1'b0, {tag, " still holding"});
        step(1'b1, 1'b1, {tag, " pending fires at H"});
        s_fa = 1'b1; s_nd = 1'b1; s_fault = 8'd0;
        step(1'b1, 1'b0, {tag, " data serviced"});
        idle(70, 1'b0, {tag, " quiet"});
    endtask

    initial begin
        s_rst = 1'b1;
        idle(3, 1'b0, "R10 in reset");
        s_rst = 1'b0;
        idle(2, 1'b0, "R10 after reset");

        // R1 / R9: data trigger on falling no-data flag
        s_nd = 1'b0; step(1'b1, 1'b1, "R1 R9 data fires");
        s_fw = 1'b1; step(1'b1, 1'b1, "R3 fault_wr keeps data");
        s_fa = 1'b1; step(1'b1, 1'b0, "R3 fifo access releases");
        idle(5, 1'b0, "R2 flag held low");
        s_nd = 1'b1; idle(30, 1'b0, "R2 flag rising");

        // R4 / R5: fault trigger and release
        s_fault = 8'h01; step(1'b1, 1'b1, "R4 fault fires");
        s_fa = 1'b1;     step(1'b1, 1'b1, "R5 fifo access keeps fault");
        s_fw = 1'b1;     step(1'b1, 1'b0, "R5 fault_wr releases");
        idle(25, 1'b0, "R4 settle");
        s_fault = 8'h03; idle(3, 1'b0, "R4 nonzero to nonzero");
        s_fault = 8'h00; step(1'b1, 1'b0, "R4 back to zero");
        s_fault = 8'h02; step(1'b1, 1'b1, "R4 zero to nonzero");
        s_fw = 1'b1;     step(1'b1, 1'b0, "R5 release again");
        s_fault = 8'h00; idle(25, 1'b0, "R4 settle");

        // R11: both sources at once
        s_nd = 1'b0; s_fault = 8'h80; step(1'b1, 1'b1, "R11 both fire");
        s_fa = 1'b1; step(1'b1, 1'b1, "R11 fault still set");
        s_fw = 1'b1; step(1'b1, 1'b0, "R11 both serviced");
        s_nd = 1'b1; s_fault = 8'h00; idle(25, 1'b0, "R11 settle");

        // R6: disabled events are ignored
        s_en = 1'b0; step(1'b1, 1'b0, "R6 disable");
        s_nd = 1'b0; step(1'b1, 1'b0, "R6 data ignored");
        s_fault = 8'h10; idle(3, 1'b0, "R6 fault ignored");
        s_en = 1'b1; idle(25, 1'b0, "R6 no late fire");
        s_nd = 1'b1; s_fault = 8'h00; idle(3, 1'b0, "R6 settle");

        // R6: pending discarded by an enable drop inside the holdoff
        s_nd = 1'b0; step(1'b1, 1'b1, "R6 fire");
        s_fa = 1'b1; step(1'b1, 1'b0, "R6 serviced");
        s_fault = 8'h04; step(1'b1, 1'b0, "R6 pended");
        s_en = 1'b0; step(1'b1, 1'b0, "R6 enable drop");
        s_en = 1'b1; idle(30, 1'b0, "R6 pending discarded");
        s_nd = 1'b1; s_fault = 8'h00; idle(3, 1'b0, "R6 settle");

        // R7 / R8: holdoff spacing
        holdoff_case(4'd1, 4'd0, 20, "R7 rate1 tp0");
        holdoff_case(4'd2, 4'd1, 48, "R7 rate2 tp1");
        holdoff_case(4'd0, 4'd2, 28, "R8 rate0 tp2");

        idle(3, 1'b0, "R10 end quiet");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule